// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which UART interrupt source is reported to software. It also drives the interrupt request line. There are four sources: a receive overrun, received data waiting, an empty transmit holding register, and a change in modem status. Each source is gated by its own enable bit. The highest-ranked enabled source that is active sets the identification value, and the request line is high while any enabled source is active.

The transmit-empty source is not a live status bit. It is a flag the unit holds internally. The flag is raised when the holding register drains. It is also raised when software turns on the transmit-empty enable while the transmit FIFO is already empty. The flag drops when a byte is written to the holding register, or when software reads the identification value while transmit-empty is the source being reported. The transmit status bits kept elsewhere are not touched.

The surrounding register file supplies the current enable bits, the status levels and single-cycle event strobes. It returns the identification value on a read. Every port is a plain control or status pin, so there is no handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: An overrun with enable bit 2 set is reported as 0x06, whatever other sources are active.
- R2: Without an enabled overrun, pending receive data with enable bit 0 set is reported as 0x04.
- R3: Without either source above, a raised transmit-empty flag with enable bit 1 set is reported as 0x02.
- R4: Without any source above, a non-zero modem status with enable bit 3 set is reported as 0x00.
- R5: When no enabled source is active, the value is 0x01. The low nibble is never 0xC, and the bits above bit 3 are always zero.
- R6: `irq` is high exactly when some enabled source is active. This is the same condition as bit 0 of the value being 0.
- R7: A `tx_drained` strobe raises the transmit-empty flag and a `tx_loaded` strobe clears it, each on the next clock edge. If both strobes come in the same cycle, the flag is raised.
- R8: A `id_rd` strobe in a cycle where the value reads 0x02 clears the flag on the next edge. A read while another source is reported leaves the flag as it is.
- R9: An enable write whose old bit 1 is 0 and new bit 1 is 1 raises the flag if `tx_fifo_empty` is high. It does nothing if the FIFO holds data or if bit 1 was already 1.
- R10: The value and `irq` follow the status and enable inputs in the same cycle, with no register delay.
- R11: A synchronous reset clears the flag, so the value returns to 0x01 when no live source is active.
- R12: When a source's enable is low, that source is not reported. A transmit-empty flag raised while its enable is low is kept, and it is reported once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ien | input | 4 | Current enables: bit0 receive data, bit1 transmit empty, bit2 overrun, bit3 modem |
| rx_overrun | input | 1 | Overrun status level |
| rx_avail | input | 1 | Receive data pending level |
| modem_stat | input | 8 | Modem status value |
| tx_fifo_empty | input | 1 | Transmit FIFO currently holds no data |
| tx_drained | input | 1 | Strobe: holding register became empty |
| tx_loaded | input | 1 | Strobe: byte written to holding register |
| id_rd | input | 1 | Strobe: identification value read |
| ien_wr | input | 1 | Strobe: enable register written |
| ien_prev | input | 4 | Enable value before that write |
| ien_next | input | 4 | Enable value written |
| id_value | output | 8 | Identification value |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions check on every cycle that an enabled overrun always wins, that code 0xC never appears, and that the request line agrees with the set of active enabled sources. They also check the flag's edge behaviour: a drained strobe or an enable rising edge raises it, a load or a read of 0x02 clears it, and reset drops it. Some things only the bench scenarios can show. These are the ranking as each source is cleared in turn, the fact that a read of another source leaves the flag in place, and that a flag raised while masked survives until it is enabled.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
  localparam int EN_W     = 4;
  localparam int EN_RXD   = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int CODE_W   = 3;

  // identification bits 3:1, ranked line > rxd > txe > modem
  typedef enum logic [CODE_W-1:0] {
    SRC_MODEM = 3'b000,
    SRC_TXE   = 3'b001,
    SRC_RXD   = 3'b010,
    SRC_LINE  = 3'b011
  } src_code_t;
endpackage

// File: rtl/irq_txe_latch.sv
module irq_txe_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= (q_r & ~clr_evt) | set_evt;
  end

  assign q = q_r;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> q_r);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !set_evt) |=> !q_r);
  p_reset_r11: assert property (@(posedge clk)
    rst |=> !q_r);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ident_pkg::*;
#(
  parameter int MSR_W = 8
) (
  input  logic [EN_W-1:0]  ien,
  input  logic             ovr,
  input  logic             rxa,
  input  logic             txe,
  input  logic [MSR_W-1:0] msr,
  output logic             pending,
  output src_code_t        code
);
  logic [EN_W-1:0] req;

  always_comb begin
    req            = '0;
    req[EN_LINE]   = ien[EN_LINE]  & ovr;
    req[EN_RXD]    = ien[EN_RXD]   & rxa;
    req[EN_TXE]    = ien[EN_TXE]   & txe;
    req[EN_MODEM]  = ien[EN_MODEM] & (|msr);
  end

  always_comb begin
    pending = 1'b1;
    code    = SRC_MODEM;
    if      (req[EN_LINE])  code = SRC_LINE;
    else if (req[EN_RXD])   code = SRC_RXD;
    else if (req[EN_TXE])   code = SRC_TXE;
    else if (req[EN_MODEM]) code = SRC_MODEM;
    else                    pending = 1'b0;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import irq_ident_pkg::*;
#(
  parameter int MSR_W = 8,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ien,
  input  logic             rx_overrun,
  input  logic             rx_avail,
  input  logic [MSR_W-1:0] modem_stat,
  input  logic             tx_fifo_empty,
  input  logic             tx_drained,
  input  logic             tx_loaded,
  input  logic             id_rd,
  input  logic             ien_wr,
  input  logic [3:0]       ien_prev,
  input  logic [3:0]       ien_next,
  output logic [ID_W-1:0]  id_value,
  output logic             irq
);
  localparam int PAD_W = ID_W - CODE_W - 1;

  logic      txe_q, pending, ien_rise, txe_set, txe_clr;
  src_code_t code;

  assign ien_rise = ien_wr & ~ien_prev[EN_TXE] & ien_next[EN_TXE] & tx_fifo_empty;
  assign txe_set  = tx_drained | ien_rise;
  assign txe_clr  = tx_loaded | (id_rd & pending & (code == SRC_TXE));

  irq_txe_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .set_evt (txe_set),
    .clr_evt (txe_clr),
    .q       (txe_q)
  );

  irq_prio_enc #(.MSR_W(MSR_W)) u_enc (
    .ien     (ien),
    .ovr     (rx_overrun),
    .rxa     (rx_avail),
    .txe     (txe_q),
    .msr     (modem_stat),
    .pending (pending),
    .code    (code)
  );

  assign id_value = {{PAD_W{1'b0}}, code, ~pending};
  assign irq      = pending;

  p_line_first_r1: assert property (@(posedge clk) disable iff (rst)
    (ien[EN_LINE] && rx_overrun) |-> (id_value == ID_W'(8'h06)));
  p_no_timeout_r5: assert property (@(posedge clk) disable iff (rst)
    id_value[3:0] != 4'hC);
  p_irq_sources_r6: assert property (@(posedge clk) disable iff (rst)
    irq == ((ien[0] & rx_avail) | (ien[1] & txe_q) | (ien[2] & rx_overrun)
            | (ien[3] & (modem_stat != '0))));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (id_rd && id_value == ID_W'(8'h02) && !txe_set) |=> !txe_q);
  p_ien_rise_r9: assert property (@(posedge clk) disable iff (rst)
    ien_rise |=> txe_q);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] ien = '0;
  logic       rx_overrun = 0, rx_avail = 0, tx_fifo_empty = 1;
  logic [7:0] modem_stat = '0;
  logic       tx_drained = 0, tx_loaded = 0, id_rd = 0, ien_wr = 0;
  logic [3:0] ien_prev = '0, ien_next = '0;
  logic [7:0] id_value;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident u0 (.*);

  // {ien[4], ovr, rxa, msr[8], expected id[8]}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {4'hF, 1'b0, 1'b0, 8'h00, 8'h01},
    {4'hF, 1'b1, 1'b0, 8'h00, 8'h06},
    {4'hF, 1'b1, 1'b1, 8'h05, 8'h06},
    {4'hF, 1'b0, 1'b1, 8'h05, 8'h04},
    {4'hF, 1'b0, 1'b0, 8'h80, 8'h00},
    {4'h0, 1'b1, 1'b1, 8'hFF, 8'h01},
    {4'hB, 1'b1, 1'b1, 8'h00, 8'h04},
    {4'hA, 1'b1, 1'b1, 8'h01, 8'h00},
    {4'h4, 1'b1, 1'b0, 8'h00, 8'h06},
    {4'h1, 1'b0, 1'b1, 8'h00, 8'h04},
    {4'h8, 1'b0, 1'b0, 8'h00, 8'h01},
    {4'h2, 1'b1, 1'b1, 8'hFF, 8'h01}
  };

  task automatic check(input string tag, input logic [7:0] exp);
    n_chk++;
    if (id_value !== exp || irq !== (exp != 8'h01)) begin
      n_fail++;
      $display("FAIL %s: id=%02h irq=%b expected id=%02h irq=%b",
               tag, id_value, irq, exp, exp != 8'h01);
    end
  endtask

  // 0 drained, 1 loaded, 2 read, 3 drained+loaded
  task automatic pulse(input int which);
    @(negedge clk);
    tx_drained = (which == 0 || which == 3);
    tx_loaded  = (which == 1 || which == 3);
    id_rd      = (which == 2);
    @(negedge clk);
    tx_drained = 0; tx_loaded = 0; id_rd = 0;
    #1;
  endtask

  task automatic ien_write(input logic [3:0] o, input logic [3:0] n, input logic fe);
    @(negedge clk);
    ien_wr = 1; ien_prev = o; ien_next = n; tx_fifo_empty = fe;
    @(negedge clk);
    ien_wr = 0; tx_fifo_empty = 1;
    #1;
  endtask

  task automatic set_lvl(input logic [3:0] e, input logic o, input logic r, input logic [7:0] m);
    @(negedge clk);
    ien = e; rx_overrun = o; rx_avail = r; modem_stat = m;
    #1;
  endtask

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R11 reset state", 8'h01);

    // R1 R2 R4 R5 R6 R10 R12: priority table, flag clear
    for (int i = 0; i < NV; i++) begin
      set_lvl(VEC[i][21:18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      check($sformatf("R1 R2 R4 R5 R6 R10 R12 vector %0d", i), VEC[i][7:0]);
    end

    // R7 set / clear / simultaneous
    set_lvl(4'h2, 0, 0, 8'h00);
    pulse(0); check("R7 drained raises flag (R3)", 8'h02);
    pulse(1); check("R7 load clears flag", 8'h01);
    pulse(3); check("R7 set wins over load", 8'h02);
    pulse(1); check("R7 load clears again", 8'h01);

    // R12 masked flag retained
    set_lvl(4'h0, 0, 0, 8'h00);
    pulse(0); check("R12 masked flag hidden", 8'h01);
    set_lvl(4'h2, 0, 0, 8'h00); check("R12 flag shown once enabled", 8'h02);

    // R8 read clears only when reported
    pulse(2); check("R8 read of 0x02 clears flag", 8'h01);
    pulse(0);
    set_lvl(4'hF, 0, 1, 8'h00); check("R8 data outranks flag", 8'h04);
    pulse(2); check("R8 read of other source", 8'h04);
    set_lvl(4'hF, 0, 0, 8'h00); check("R8 flag kept after other read", 8'h02);
    pulse(1);

    // R9 enable rising edge
    set_lvl(4'h2, 0, 0, 8'h00);
    ien_write(4'h0, 4'h2, 1); check("R9 enable rise with empty fifo", 8'h02);
    pulse(1);
    ien_write(4'h0, 4'h2, 0); check("R9 no raise when fifo holds data", 8'h01);
    ien_write(4'h2, 4'h2, 1); check("R9 no raise without edge", 8'h01);

    // R1..R4 chain: clearing top exposes next
    pulse(0);
    set_lvl(4'hF, 1, 1, 8'h00); check("R1 chain overrun first", 8'h06);
    set_lvl(4'hF, 0, 1, 8'h00); check("R2 chain data next", 8'h04);
    set_lvl(4'hF, 0, 0, 8'h00); check("R3 chain tx empty next", 8'h02);
    pulse(2);
    set_lvl(4'hF, 0, 0, 8'h40); check("R4 chain modem last", 8'h00);
    set_lvl(4'hF, 0, 0, 8'h00); check("R5 chain all clear", 8'h01);

    // R11 mid-run reset drops flag
    pulse(0); check("R11 flag before reset", 8'h02);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    check("R11 reset clears flag", 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule